// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received frame should be kept, judging only by its 6-byte destination address. The address bytes arrive one per valid cycle, first byte on the wire first. Once the last address byte has been taken, the block registers an accept/reject verdict and a group flag. Both stay on the outputs until the next frame begins.

The filter checks its rules in a fixed order, and each rule has its own enable bit in a receive-configuration byte:
- promiscuous acceptance comes first;
- then all-ones broadcast;
- then group (multicast) addresses, which are looked up in a 64-bit hash table;
- last, an exact compare against the stored station address.

A companion CRC unit supplies the 6-bit hash index. The filter samples that index together with the sixth byte. The station address, the configuration byte and the hash table are loaded through a byte-wide register write port.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `decisionValid`, `acceptFrame` and `groupFrame` are 0, and the station address, configuration byte and hash table are all zero. With these values, an all-zero destination is therefore accepted as a unicast match.
- R2: The write port stores station byte k (k = 0..5, byte 0 first on the wire) at address k, the configuration byte at address 6, and hash byte j (j = 0..7) at address 8+j. A write to address 7 changes nothing.
- R3: When configuration bit 4 is 1, every frame is accepted.
- R4: A destination of six 0xFF bytes is broadcast. Unless R3 applies, it is accepted exactly when configuration bit 2 is 1.
- R5: Any other destination whose first byte has bit 0 set is group-addressed. Unless R3 applies, it is accepted only when configuration bit 3 is 1 and the hash table bit at byte index>>3, bit index&7 is 1.
- R6: A destination with bit 0 of its first byte clear is accepted (unless R3 applies) only when all six bytes equal the stored station bytes.
- R7: `decisionValid` rises in the cycle after the sixth address byte is taken, and stays low before that. The verdict and group flag hold until a `frameStart`. A `frameStart` clears all three outputs in the next cycle.
- R8: A `frameStart` in the same cycle as `byteValid` makes that byte the first address byte. A `frameStart` alone makes the next valid byte the first.
- R9: Bytes arriving after the sixth, or outside a frame, are ignored. `hashIdx` is used only in the cycle of the sixth byte.
- R10: Idle cycles (`byteValid` low) between address bytes do not change the outcome.
- R11: `groupFrame` equals bit 0 of the first address byte, including for broadcast.
- R12: Broadcast takes precedence over the group lookup. An all-ones destination with bit 2 clear is rejected even when bit 3 is set and the hash bit hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 4 | Register write address |
| cfgWrData | input | 8 | Register write data |
| frameStart | input | 1 | Start of a new frame |
| byteValid | input | 1 | Address byte present on `byteData` |
| byteData | input | 8 | Destination address byte |
| hashIdx | input | 6 | Hash index from the CRC unit, sampled with the sixth byte |
| decisionValid | output | 1 | Verdict is valid |
| acceptFrame | output | 1 | Frame accepted |
| groupFrame | output | 1 | Destination is a group address |

## Verification
The embedded properties assume the following input behaviour:
- `frameStart` is a single-cycle pulse.
- Address bytes arrive only while a frame is open.
- The configuration is stable over the cycle in which the sixth byte is taken.

The directed stimulus writes registers only between frames. It drives every frame with `frameStart`, either alongside the first byte or alone one cycle before it. It also deliberately injects stray bytes after a verdict, and drives a wrong `hashIdx` on every byte except the sixth, to exercise the rules on ignored input.

// File: rtl/dest_filter_pkg.sv
package dest_filter_pkg;
  // Configuration bit positions (behavioural: the bench programs these)
  localparam int CFG_BCAST_BIT   = 2;
  localparam int CFG_GROUP_BIT   = 3;
  localparam int CFG_PROMISC_BIT = 4;

  typedef struct packed {
    logic clearDecision;
    logic takeByte;
    logic firstByte;
    logic lastByte;
  } filtStrobe_t;
endpackage

// File: rtl/dest_filter_regs.sv
module dest_filter_regs #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BYTES = 8,
  parameter int BYTE_W     = 8,
  parameter int REG_AW     = 4,
  parameter int CFG_ADDR   = 6,
  parameter int HASH_BASE  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfgWrEn,
  input  logic [REG_AW-1:0]            cfgAddr,
  input  logic [BYTE_W-1:0]            cfgWrData,
  output logic [ADDR_BYTES*BYTE_W-1:0] stationFlat,
  output logic [HASH_BYTES*BYTE_W-1:0] hashFlat,
  output logic                         promiscEn,
  output logic                         bcastEn,
  output logic                         groupEn
);
  import dest_filter_pkg::*;

  for (genvar gi = 0; gi < ADDR_BYTES; gi++) begin : g_station
    always_ff @(posedge clk) begin
      if (!rst_n)
        stationFlat[gi*BYTE_W +: BYTE_W] <= '0;
      else if (cfgWrEn && cfgAddr == REG_AW'(gi))
        stationFlat[gi*BYTE_W +: BYTE_W] <= cfgWrData;
    end
  end

  for (genvar gj = 0; gj < HASH_BYTES; gj++) begin : g_hash
    always_ff @(posedge clk) begin
      if (!rst_n)
        hashFlat[gj*BYTE_W +: BYTE_W] <= '0;
      else if (cfgWrEn && cfgAddr == REG_AW'(HASH_BASE + gj))
        hashFlat[gj*BYTE_W +: BYTE_W] <= cfgWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      promiscEn <= 1'b0;
      bcastEn   <= 1'b0;
      groupEn   <= 1'b0;
    end else if (cfgWrEn && cfgAddr == REG_AW'(CFG_ADDR)) begin
      promiscEn <= cfgWrData[CFG_PROMISC_BIT];
      bcastEn   <= cfgWrData[CFG_BCAST_BIT];
      groupEn   <= cfgWrData[CFG_GROUP_BIT];
    end
  end

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && cfgAddr == REG_AW'(CFG_ADDR)) |=>
      (promiscEn == $past(cfgWrData[CFG_PROMISC_BIT]) &&
       bcastEn   == $past(cfgWrData[CFG_BCAST_BIT])));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfgWrEn && cfgAddr == REG_AW'(CFG_ADDR)) |=>
      ($stable(promiscEn) && $stable(bcastEn) && $stable(groupEn)));
endmodule

// File: rtl/dest_filter_ctrl.sv
module dest_filter_ctrl #(
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W = $clog2(ADDR_BYTES + 1),
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frameStart,
  input  logic                        byteValid,
  output dest_filter_pkg::filtStrobe_t strb,
  output logic [IDX_W-1:0]            byteIdx
);
  import dest_filter_pkg::*;

  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] effIdx;
  logic             take;

  always_comb begin
    effIdx  = frameStart ? '0 : byteCnt;
    take    = byteValid && (effIdx < CNT_W'(ADDR_BYTES));
    byteIdx = IDX_W'(effIdx);
    strb.clearDecision = frameStart;
    strb.takeByte      = take;
    strb.firstByte     = take && (effIdx == '0);
    strb.lastByte      = take && (effIdx == CNT_W'(ADDR_BYTES - 1));
  end

  // Counter idles saturated at ADDR_BYTES, so bytes outside a frame fall through.
  always_ff @(posedge clk) begin
    if (!rst_n)
      byteCnt <= CNT_W'(ADDR_BYTES);
    else if (take)
      byteCnt <= effIdx + CNT_W'(1);
    else if (frameStart)
      byteCnt <= '0;
  end

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byteCnt <= CNT_W'(ADDR_BYTES));

  // R8
  start_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStart && byteValid) |=> (byteCnt == CNT_W'(1)));

  // R8
  start_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frameStart && !byteValid) |=> (byteCnt == '0));

  // R9
  saturated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byteCnt == CNT_W'(ADDR_BYTES) && !frameStart) |=> (byteCnt == CNT_W'(ADDR_BYTES)));
endmodule

// File: rtl/dest_filter_datapath.sv
module dest_filter_datapath #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BYTES = 8,
  parameter int BYTE_W     = 8,
  localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int HIDX_W = $clog2(HASH_BYTES * BYTE_W)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  dest_filter_pkg::filtStrobe_t strb,
  input  logic [IDX_W-1:0]             byteIdx,
  input  logic [BYTE_W-1:0]            byteData,
  input  logic [HIDX_W-1:0]            hashIdx,
  input  logic [ADDR_BYTES*BYTE_W-1:0] stationFlat,
  input  logic [HASH_BYTES*BYTE_W-1:0] hashFlat,
  input  logic                         promiscEn,
  input  logic                         bcastEn,
  input  logic                         groupEn,
  output logic                         decisionValid,
  output logic                         acceptFrame,
  output logic                         groupFrame
);
  import dest_filter_pkg::*;

  logic [BYTE_W-1:0] stationByte;
  logic onesRun, eqRun, groupRun;
  logic onesNow, eqNow, groupNow, hashHit, acceptNow;

  always_comb begin
    stationByte = stationFlat[byteIdx*BYTE_W +: BYTE_W];
    onesNow  = (&byteData) && (strb.firstByte || onesRun);
    eqNow    = (byteData == stationByte) && (strb.firstByte || eqRun);
    groupNow = strb.firstByte ? byteData[0] : groupRun;
    hashHit  = hashFlat[hashIdx];
    if (promiscEn)      acceptNow = 1'b1;
    else if (onesNow)   acceptNow = bcastEn;
    else if (groupNow)  acceptNow = groupEn && hashHit;
    else                acceptNow = eqNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      onesRun  <= 1'b0;
      eqRun    <= 1'b0;
      groupRun <= 1'b0;
    end else if (strb.takeByte) begin
      onesRun  <= onesNow;
      eqRun    <= eqNow;
      groupRun <= groupNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decisionValid <= 1'b0;
      acceptFrame   <= 1'b0;
      groupFrame    <= 1'b0;
    end else if (strb.lastByte) begin
      decisionValid <= 1'b1;
      acceptFrame   <= acceptNow;
      groupFrame    <= groupNow;
    end else if (strb.clearDecision) begin
      decisionValid <= 1'b0;
      acceptFrame   <= 1'b0;
      groupFrame    <= 1'b0;
    end
  end

  // R7
  decision_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decisionValid) |-> $past(strb.lastByte));

  // R7
  decision_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decisionValid && !strb.clearDecision && !strb.lastByte) |=>
      (decisionValid && $stable(acceptFrame) && $stable(groupFrame)));

  // R7
  decision_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.clearDecision && !strb.lastByte) |=> !decisionValid);

  // R3
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.lastByte && promiscEn) |=> acceptFrame);

  // R12
  bcast_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.lastByte && !promiscEn && !bcastEn && onesNow) |=> !acceptFrame);

  // R11
  bcast_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.lastByte && onesNow) |=> groupFrame);
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BYTES = 8,
  parameter int BYTE_W     = 8,
  parameter int REG_AW     = 4,
  localparam int IDX_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int HIDX_W = $clog2(HASH_BYTES * BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [REG_AW-1:0] cfgAddr,
  input  logic [BYTE_W-1:0] cfgWrData,
  input  logic              frameStart,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [HIDX_W-1:0] hashIdx,
  output logic              decisionValid,
  output logic              acceptFrame,
  output logic              groupFrame
);
  import dest_filter_pkg::*;

  filtStrobe_t                  strb;
  logic [IDX_W-1:0]             byteIdx;
  logic [ADDR_BYTES*BYTE_W-1:0] stationFlat;
  logic [HASH_BYTES*BYTE_W-1:0] hashFlat;
  logic                         promiscEn, bcastEn, groupEn;

  dest_filter_regs #(
    .ADDR_BYTES(ADDR_BYTES), .HASH_BYTES(HASH_BYTES), .BYTE_W(BYTE_W),
    .REG_AW(REG_AW), .CFG_ADDR(ADDR_BYTES), .HASH_BASE(8)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .stationFlat(stationFlat), .hashFlat(hashFlat),
    .promiscEn(promiscEn), .bcastEn(bcastEn), .groupEn(groupEn)
  );

  dest_filter_ctrl #(.ADDR_BYTES(ADDR_BYTES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .frameStart(frameStart), .byteValid(byteValid),
    .strb(strb), .byteIdx(byteIdx)
  );

  dest_filter_datapath #(
    .ADDR_BYTES(ADDR_BYTES), .HASH_BYTES(HASH_BYTES), .BYTE_W(BYTE_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .byteIdx(byteIdx),
    .byteData(byteData), .hashIdx(hashIdx), .stationFlat(stationFlat),
    .hashFlat(hashFlat), .promiscEn(promiscEn), .bcastEn(bcastEn),
    .groupEn(groupEn), .decisionValid(decisionValid),
    .acceptFrame(acceptFrame), .groupFrame(groupFrame)
  );
endmodule

// File: tb/dest_addr_filter_tb.sv
module dest_addr_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [7:0] cfgWrData = '0;
  logic       frameStart = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic [5:0] hashIdx = '0;
  logic       decisionValid, acceptFrame, groupFrame;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Bench-side copy of programmed state
  logic [47:0] tbStation = '0;
  logic [63:0] tbHash = '0;
  logic [7:0]  tbCfg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dest_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .frameStart(frameStart), .byteValid(byteValid),
    .byteData(byteData), .hashIdx(hashIdx), .decisionValid(decisionValid),
    .acceptFrame(acceptFrame), .groupFrame(groupFrame)
  );

  task automatic checkVal(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a <= 4'd5) tbStation[47 - 8*a -: 8] = d;
    else if (a == 4'd6) tbCfg = d;
    else if (a >= 4'd8) tbHash[8*(a-8) +: 8] = d;
  endtask

  function automatic logic expAccept(input logic [47:0] da, input logic [5:0] idx);
    if (tbCfg[4]) return 1'b1;
    if (da == '1) return tbCfg[2];
    if (da[40]) return tbCfg[3] && tbHash[idx];
    return da == tbStation;
  endfunction

  // Leaves the bench at the negedge after the sixth byte's capturing edge.
  task automatic driveFrame(input logic [47:0] da, input logic [5:0] idx,
                            input int gap, input bit startAlone);
    @(negedge clk);
    if (startAlone) begin
      frameStart = 1'b1; byteValid = 1'b0;
      @(negedge clk);
      frameStart = 1'b0;
    end
    for (int i = 0; i < 6; i++) begin
      frameStart = (i == 0) && !startAlone;
      byteValid  = 1'b1;
      byteData   = da[47 - 8*i -: 8];
      hashIdx    = (i == 5) ? idx : ~idx;
      @(negedge clk);
      frameStart = 1'b0; byteValid = 1'b0; hashIdx = ~idx;
      if (i < 5) begin
        checkVal("R7 no early verdict", {7'b0, decisionValid}, 8'h00);
        repeat (gap) @(negedge clk);
      end
    end
  endtask

  task automatic runFrame(input string tag, input logic [47:0] da,
                          input logic [5:0] idx, input int gap, input bit startAlone);
    driveFrame(da, idx, gap, startAlone);
    checkVal({tag, " valid"},  {7'b0, decisionValid}, 8'h01);
    checkVal({tag, " accept"}, {7'b0, acceptFrame}, {7'b0, expAccept(da, idx)});
    checkVal({tag, " group"},  {7'b0, groupFrame},  {7'b0, da[40]});
  endtask

  task automatic testReset;
    checkVal("R1 reset valid",  {7'b0, decisionValid}, 8'h00);
    checkVal("R1 reset accept", {7'b0, acceptFrame}, 8'h00);
    checkVal("R1 reset group",  {7'b0, groupFrame}, 8'h00);
    runFrame("R1 zero station match", 48'h0, 6'd0, 0, 0);
  endtask

  task automatic testUnicast;
    writeReg(4'd0, 8'h02); writeReg(4'd1, 8'h11); writeReg(4'd2, 8'h22);
    writeReg(4'd3, 8'h33); writeReg(4'd4, 8'h44); writeReg(4'd5, 8'h55);
    writeReg(4'd7, 8'h1C); // R2: unmapped, must not enable anything
    runFrame("R2 R6 station match", 48'h021122334455, 6'd3, 0, 0);
    runFrame("R2 unmapped write ignored", 48'h021122334456, 6'd3, 0, 0);
    runFrame("R6 first byte mismatch", 48'h061122334455, 6'd3, 0, 0);
  endtask

  task automatic testBroadcast;
    runFrame("R4 R11 bcast disabled", 48'hFFFFFFFFFFFF, 6'd1, 0, 0);
    writeReg(4'd6, 8'h04);
    runFrame("R4 bcast enabled", 48'hFFFFFFFFFFFF, 6'd1, 0, 0);
  endtask

  task automatic testGroup;
    writeReg(4'd6, 8'h00);
    writeReg(4'd13, 8'h20); // bit 45
    runFrame("R5 group disabled", 48'h01005E000001, 6'd45, 0, 0);
    writeReg(4'd6, 8'h08);
    runFrame("R5 R9 hash hit", 48'h01005E000001, 6'd45, 0, 0);
    runFrame("R5 hash miss", 48'h01005E000001, 6'd44, 0, 0);
    runFrame("R12 bcast over group", 48'hFFFFFFFFFFFF, 6'd45, 0, 0);
  endtask

  task automatic testPromisc;
    writeReg(4'd6, 8'h10);
    runFrame("R3 promisc unicast", 48'h0A0B0C0D0E0F, 6'd0, 0, 0);
    runFrame("R3 promisc group", 48'h030000000000, 6'd9, 0, 0);
    writeReg(4'd6, 8'h00);
  endtask

  task automatic testFraming;
    runFrame("R10 gaps match", 48'h021122334455, 6'd0, 3, 0);
    runFrame("R8 start alone", 48'h021122334455, 6'd0, 1, 1);
    repeat (5) @(negedge clk);
    checkVal("R7 hold valid", {7'b0, decisionValid}, 8'h01);
    checkVal("R7 hold accept", {7'b0, acceptFrame}, 8'h01);
    for (int i = 0; i < 3; i++) begin
      byteValid = 1'b1; byteData = 8'hFF;
      @(negedge clk);
    end
    byteValid = 1'b0;
    @(negedge clk);
    checkVal("R9 stray bytes valid", {7'b0, decisionValid}, 8'h01);
    checkVal("R9 stray bytes accept", {7'b0, acceptFrame}, 8'h01);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    checkVal("R7 clear valid", {7'b0, decisionValid}, 8'h00);
    checkVal("R7 clear accept", {7'b0, acceptFrame}, 8'h00);
    // Bytes after the cleared frame's start but a fresh frame still decides normally
    runFrame("R8 R6 mismatch after clear", 48'h021122334400, 6'd0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testUnicast();
    testBroadcast();
    testGroup();
    testPromisc();
    testFraming();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule